// File: doc/BRIEF.md
# Receive Interrupt Coalescing Controller

This block gathers the event pulses of a network MAC port into a raw status register, masks them through an enable register, and drives one level-sensitive interrupt line toward the host. Three event inputs feed it, each a single-cycle pulse: a frame was received, a frame was transmitted, and the transmit queue drained. The host reads and writes the registers over a plain 32-bit bus with a write strobe and a combinational read path.

Received frames are tracked two ways. A per-frame status bit stays set while any received frame has not yet been taken by software, and each write-1 to it takes one frame. A merged status bit fires when the number of waiting frames reaches a programmable threshold, or when a programmable number of idle cycles passes after the latest frame while frames still wait. Software that enables only the merged bit gets one interrupt per batch instead of one per frame.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After reset the status register reads 0, the enable register reads 0, the coalescing register reads 0x08000074 (threshold 8, timeout 0x74) and `irq` is low.
- R2: Registers sit at byte address 0x00 (status), 0x04 (enable) and 0x08 (coalescing); the enable register keeps only bits 7:0 (event mask), 18 (port enable) and 19 (global enable); the coalescing register holds the threshold in bits 31:24 and the timeout in its low `TMO_W` bits; any other address reads 0.
- R3: A transmit pulse sets status bit 1 and a drained pulse sets status bit 6; each stays set until a 1 is written to it, and writing 0 to a status bit leaves it unchanged.
- R4: Status bit 0 reads 1 whenever at least one received frame is waiting; writing 1 to bit 0 takes exactly one waiting frame.
- R5: With a nonzero threshold, status bit 7 sets on the clock edge of the frame arrival that brings the waiting count to or above the threshold.
- R6: With a nonzero timeout T, status bit 7 sets on the T-th clock edge after the latest frame arrival if frames still wait; each new frame restarts that count, and a timeout of 0 disables it.
- R7: A status bit that is set and cleared by a write in the same cycle ends up set; a frame arrival and a take of one frame in the same cycle leave the waiting count unchanged.
- R8: `irq` is high exactly when some status bit among 7:0 is set with its mask bit set, and both the port enable (bit 18) and global enable (bit 19) are set.
- R9: Writing 0xFF to the status register clears bits 1, 6 and 7 and takes one waiting frame.
- R10: The waiting-frame count saturates at 2^`PEND_W`-1 and never wraps to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_rx_frame | input | 1 | Pulse: one frame received |
| ev_tx_frame | input | 1 | Pulse: one frame transmitted |
| ev_tx_drained | input | 1 | Pulse: transmit queue became empty |
| irq | output | 1 | Level interrupt toward the host |

## Verification
The bench builds the block with a 3-bit waiting counter and an 8-bit timeout field. The narrow counter lets nine arrivals drive it into saturation, so the non-wrapping rule and the seven takes needed to empty it are observable within a few dozen cycles. The 8-bit timeout still holds the 0x74 reset value, and small programmed timeouts of ten cycles make the exact expiry edge and the restart-on-arrival behaviour checkable cycle by cycle.

// File: rtl/irq_coal_pkg.sv
// Shared constants of the interrupt coalescing controller: register byte
// addresses, status and enable bit positions, reset values.
package irq_coal_pkg;
    localparam logic [7:0] ADDR_STAT = 8'h00;
    localparam logic [7:0] ADDR_ENA  = 8'h04;
    localparam logic [7:0] ADDR_COAL = 8'h08;

    localparam int BIT_RX_ONE  = 0;
    localparam int BIT_TX_ONE  = 1;
    localparam int BIT_DRAINED = 6;
    localparam int BIT_RX_MULT = 7;
    localparam int BIT_PORT_EN = 18;
    localparam int BIT_GLB_EN  = 19;
    localparam int THR_LSB     = 24;
    localparam int THR_W       = 8;
    localparam int NEV         = 8;

    // Bits that are write-1-to-clear latches (bit 0 is derived from the count)
    localparam logic [NEV-1:0] STICKY_MASK = 8'b1100_0010;

    localparam logic [THR_W-1:0] THR_RESET = 8'd8;
    localparam int               TMO_RESET = 'h74;
endpackage

// File: rtl/coal_core.sv
// Counts received frames that software has not yet taken and times the idle
// gap since the latest arrival. Raises multi_set for one cycle when the count
// reaches the threshold or the idle timer expires with frames still waiting.
// Assumes rx_pulse and consume are single-cycle strobes.
module coal_core #(
    parameter int PEND_W = 8,
    parameter int TMO_W  = 16,
    parameter int THR_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_pulse,
    input  logic             consume,
    input  logic [THR_W-1:0] thr,
    input  logic [TMO_W-1:0] tmo,
    output logic             pending,
    output logic             multi_set
);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;
    localparam int               CMP_W    = 32;

    logic [PEND_W-1:0] pend_q, pend_d;
    logic [TMO_W-1:0]  tmr_q;
    logic              inc, dec, thr_hit, tmo_hit;

    // Next waiting count, saturating at the top
    always_comb begin
        dec    = consume && (pend_q != '0);
        inc    = rx_pulse && ((pend_q != PEND_MAX) || dec);
        pend_d = pend_q + PEND_W'(inc) - PEND_W'(dec);
    end

    // Threshold and timeout triggers for the merged event
    always_comb begin
        thr_hit = rx_pulse && (thr != '0) &&
                  (CMP_W'(pend_d) >= CMP_W'(thr));
        tmo_hit = (pend_q != '0) && !rx_pulse && (tmo != '0) &&
                  (({1'b0, tmr_q} + (TMO_W+1)'(1)) >= {1'b0, tmo});
        multi_set = thr_hit || tmo_hit;
    end

    // Waiting-frame counter
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Idle timer: restarts on arrival or expiry, held at zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n)                                   tmr_q <= '0;
        else if (rx_pulse || pend_q == '0 || tmo_hit) tmr_q <= '0;
        else                                          tmr_q <= tmr_q + 1'b1;
    end

    assign pending = (pend_q != '0);

    // R10
    pend_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == PEND_MAX && rx_pulse && !consume) |=> (pend_q == PEND_MAX));
    // R4
    pend_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (consume && !rx_pulse && pend_q != '0) |=> (pend_q == $past(pend_q) - PEND_W'(1)));
    // R6
    tmr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |=> (tmr_q == '0));
endmodule

// File: rtl/status_bits.sv
// Write-1-to-clear event latches. One flop per bit selected in MASK; other
// bits read as 0. A set in the same cycle as a clear wins.
module status_bits #(
    parameter int            NB   = 8,
    parameter logic [NB-1:0] MASK = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_i,
    input  logic [NB-1:0] clr_i,
    output logic [NB-1:0] q
);
    for (genvar i = 0; i < NB; i++) begin : g_bit
        if (MASK[i]) begin : g_flop
            logic b_q;
            // Latch the event, clear on write-1, set has priority
            always_ff @(posedge clk) begin
                if (!rst_n) b_q <= 1'b0;
                else        b_q <= set_i[i] | (b_q & ~clr_i[i]);
            end
            assign q[i] = b_q;

            // R7
            set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> q[i]);
        end else begin : g_none
            assign q[i] = 1'b0;
        end
    end
endmodule

// File: rtl/rx_irq_coalescer.sv
// Top of the interrupt coalescing controller. Decodes the register bus,
// holds the enable and coalescing registers, merges event pulses into the
// status latches and drives the level interrupt. Assumes one bus write per
// cycle at most and single-cycle event pulses.
module rx_irq_coalescer
    import irq_coal_pkg::*;
#(
    parameter int PEND_W = 8,
    parameter int TMO_W  = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        ev_rx_frame,
    input  logic        ev_tx_frame,
    input  logic        ev_tx_drained,
    output logic        irq
);
    logic [NEV-1:0]   ena_q;
    logic             port_en_q, glb_en_q;
    logic [THR_W-1:0] thr_q;
    logic [TMO_W-1:0] tmo_q;
    logic [NEV-1:0]   set_vec, clr_vec, sticky, stat_vec;
    logic             pending, multi_set, consume;
    logic             wr_stat, wr_ena, wr_coal;
    logic             unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // Write strobes per register
    always_comb begin
        wr_stat = bus_wr && (bus_addr == ADDR_STAT);
        wr_ena  = bus_wr && (bus_addr == ADDR_ENA);
        wr_coal = bus_wr && (bus_addr == ADDR_COAL);
        clr_vec = wr_stat ? bus_wdata[NEV-1:0] : '0;
        consume = clr_vec[BIT_RX_ONE];
    end

    // Enable register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q     <= '0;
            port_en_q <= 1'b0;
            glb_en_q  <= 1'b0;
        end else if (wr_ena) begin
            ena_q     <= bus_wdata[NEV-1:0];
            port_en_q <= bus_wdata[BIT_PORT_EN];
            glb_en_q  <= bus_wdata[BIT_GLB_EN];
        end
    end

    // Coalescing register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr_q <= THR_RESET;
            tmo_q <= TMO_W'(TMO_RESET);
        end else if (wr_coal) begin
            thr_q <= bus_wdata[THR_LSB +: THR_W];
            tmo_q <= bus_wdata[TMO_W-1:0];
        end
    end

    coal_core #(.PEND_W(PEND_W), .TMO_W(TMO_W), .THR_W(THR_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_pulse  (ev_rx_frame),
        .consume   (consume),
        .thr       (thr_q),
        .tmo       (tmo_q),
        .pending   (pending),
        .multi_set (multi_set)
    );

    // Route event pulses to their status positions
    always_comb begin
        set_vec              = '0;
        set_vec[BIT_TX_ONE]  = ev_tx_frame;
        set_vec[BIT_DRAINED] = ev_tx_drained;
        set_vec[BIT_RX_MULT] = multi_set;
    end

    status_bits #(.NB(NEV), .MASK(STICKY_MASK)) u_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_vec),
        .clr_i (clr_vec),
        .q     (sticky)
    );

    assign stat_vec = sticky | NEV'(pending);

    // Register read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_STAT: bus_rdata[NEV-1:0] = stat_vec;
            ADDR_ENA: begin
                bus_rdata[NEV-1:0]   = ena_q;
                bus_rdata[BIT_PORT_EN] = port_en_q;
                bus_rdata[BIT_GLB_EN]  = glb_en_q;
            end
            ADDR_COAL: begin
                bus_rdata[THR_LSB +: THR_W] = thr_q;
                bus_rdata[TMO_W-1:0]        = tmo_q;
            end
            default: bus_rdata = '0;
        endcase
    end

    // Interrupt line: masked status, gated by port and global enables
    assign irq = (|(stat_vec & ena_q)) && port_en_q && glb_en_q;

    // R4
    rx_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_frame |=> stat_vec[BIT_RX_ONE]);
endmodule

// File: tb/sim_rx_irq_coalescer.sv
`timescale 1ns/1ps
module sim_rx_irq_coalescer;
    localparam int PEND_W = 3;
    localparam int TMO_W  = 8;

    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_EV = 2'd2;
    localparam int NV = 14;
    // {req[3:0], kind[1:0], addr[7:0], data[31:0]}; for K_RD data is expected,
    // for K_EV data[2:0] = {drained, tx, rx}
    localparam logic [45:0] VEC [NV] = '{
        {4'd2, K_WR, 8'h04, 32'hFFFF_FFFF},
        {4'd2, K_RD, 8'h04, 32'h000C_00FF},
        {4'd2, K_RD, 8'h0C, 32'h0000_0000},
        {4'd3, K_EV, 8'h00, 32'h0000_0002},
        {4'd3, K_RD, 8'h00, 32'h0000_0002},
        {4'd3, K_EV, 8'h00, 32'h0000_0004},
        {4'd3, K_RD, 8'h00, 32'h0000_0042},
        {4'd3, K_WR, 8'h00, 32'h0000_0000},
        {4'd3, K_RD, 8'h00, 32'h0000_0042},
        {4'd3, K_WR, 8'h00, 32'h0000_0002},
        {4'd3, K_RD, 8'h00, 32'h0000_0040},
        {4'd3, K_WR, 8'h00, 32'h0000_0040},
        {4'd3, K_RD, 8'h00, 32'h0000_0000},
        {4'd2, K_WR, 8'h08, 32'h0300_0005}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ev_rx_frame = 1'b0, ev_tx_frame = 1'b0, ev_tx_drained = 1'b0;
    logic        irq;
    int          total = 0, bad = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    rx_irq_coalescer #(.PEND_W(PEND_W), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rx_frame(ev_rx_frame),
        .ev_tx_frame(ev_tx_frame), .ev_tx_drained(ev_tx_drained), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock with optional write and events driven together
    task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                        input logic [2:0] ev);
        @(negedge clk);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        {ev_tx_drained, ev_tx_frame, ev_rx_frame} = ev;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        {ev_tx_drained, ev_tx_frame, ev_rx_frame} = 3'b000;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 3'b000);
    endtask

    task automatic rx();
        step(1'b0, 8'h00, 32'h0, 3'b001);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 32'h0, 3'b000);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a; #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input logic exp);
        @(negedge clk); #1;
        chk(req, {31'b0, irq}, {31'b0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd_chk("R1 stat", 8'h00, 32'h0);
        rd_chk("R1 ena", 8'h04, 32'h0);
        rd_chk("R1 coal", 8'h08, 32'h0800_0074);
        irq_chk("R1 irq", 1'b0);

        // Table walk: register map and sticky event bits (R2, R3)
        for (int i = 0; i < NV; i++) begin
            logic [45:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[45:42], i);
            case (v[41:40])
                K_WR:    wr(v[39:32], v[31:0]);
                K_EV:    step(1'b0, 8'h00, 32'h0, v[2:0]);
                default: rd_chk(tag, v[39:32], v[31:0]);
            endcase
        end
        rd_chk("R2 coal readback", 8'h08, 32'h0300_0005);
        wr(8'h04, 32'h0);

        // R5 threshold 3, timeout off
        wr(8'h08, 32'h0300_0000);
        rx(); rx();
        rd_chk("R5 below threshold", 8'h00, 32'h01);
        rx();
        rd_chk("R5 at threshold", 8'h00, 32'h81);

        // R4 each write-1 to bit 0 takes one frame
        wr(8'h00, 32'h81);
        rd_chk("R4 two left", 8'h00, 32'h01);
        wr(8'h00, 32'h01);
        rd_chk("R4 one left", 8'h00, 32'h01);
        wr(8'h00, 32'h01);
        rd_chk("R4 none left", 8'h00, 32'h00);

        // R10 saturation of the 3-bit count at 7
        wr(8'h08, 32'h0);
        for (int i = 0; i < 9; i++) rx();
        for (int i = 0; i < 6; i++) wr(8'h00, 32'h01);
        rd_chk("R10 one left after six takes", 8'h00, 32'h01);
        wr(8'h00, 32'h01);
        rd_chk("R10 empty after seven takes", 8'h00, 32'h00);

        // R7 set and clear in one cycle
        step(1'b1, 8'h00, 32'h02, 3'b010);
        rd_chk("R7 set beats clear", 8'h00, 32'h02);
        rx();
        step(1'b1, 8'h00, 32'h01, 3'b001);
        rd_chk("R7 arrive and take", 8'h00, 32'h03);
        wr(8'h00, 32'h01);
        rd_chk("R7 count was one", 8'h00, 32'h02);

        // R9 write 0xFF
        wr(8'h08, 32'h0100_0000);
        rx(); rx();
        step(1'b0, 8'h00, 32'h0, 3'b100);
        rd_chk("R9 before", 8'h00, 32'hC3);
        wr(8'h00, 32'hFF);
        rd_chk("R9 after", 8'h00, 32'h01);
        wr(8'h00, 32'h01);

        // R6 timeout of 10 cycles
        wr(8'h08, 32'h0000_000A);
        rx(); idle(9);
        rd_chk("R6 before expiry", 8'h00, 32'h01);
        idle(1);
        rd_chk("R6 at expiry", 8'h00, 32'h81);
        wr(8'h00, 32'h80);
        rx(); idle(5); rx(); idle(9);
        rd_chk("R6 restart on arrival", 8'h00, 32'h01);
        idle(1);
        rd_chk("R6 expiry after restart", 8'h00, 32'h81);
        wr(8'h08, 32'h0);
        wr(8'h00, 32'h80);
        idle(20);
        rd_chk("R6 timeout zero disables", 8'h00, 32'h01);

        // R8 interrupt gating
        step(1'b0, 8'h00, 32'h0, 3'b010);
        wr(8'h04, 32'h000C_0002);
        irq_chk("R8 masked source on", 1'b1);
        wr(8'h04, 32'h0008_0002);
        irq_chk("R8 port enable off", 1'b0);
        wr(8'h04, 32'h0004_0002);
        irq_chk("R8 global enable off", 1'b0);
        wr(8'h04, 32'h000C_0040);
        irq_chk("R8 mask on clear bit", 1'b0);
        wr(8'h04, 32'h000C_0002);
        wr(8'h00, 32'h02);
        irq_chk("R8 source cleared", 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule